// File: doc/BRIEF.md
# Bus Initiator Address Phase with Master Abort

This block is the initiator end of a shared parallel bus, limited to the address phase of a transaction. A requester presents an address, a command code and a write flag, and holds a request line high. When the bus grant is held and nobody is using the bus, the block puts the address and command on the bus for exactly one cycle and pulls the active-low frame line low. It then releases the address and command lines while keeping frame asserted, and watches the active-low device-select line for a target to claim the cycle.

If a target claims the cycle inside the response window, the requester gets an acknowledge pulse marked as claimed. If no target responds by the abort cycle, the block deasserts frame and ends the cycle itself. It then acknowledges with an abort marking and, for a read, returns all-ones data. A sticky error flag records the abort until the requester clears it with a write-one pulse. Every bus signal is given as a value plus an output enable, so the bus can be wired up as tri-state.

Top module: `ainit_addr_phase`

## Requirements
- R1: After reset, all bus output enables (`ad_oe`, `cbe_oe`, `frame_oe`) are 0, and `ack` and `abort_sticky` are 0.
- R2: A transaction starts only when `req_valid`=1, `gnt_n`=0, `frame_in_n`=1 and `irdy_in_n`=1 are all sampled together on one clock edge. While any of these does not hold, every bus output enable stays 0.
- R3: The cycle after the start edge (phase cycle 1) drives `ad_oe`=1, `cbe_oe`=1, `ad_out`=request address, `cbe_out`=request command, `frame_oe`=1 and `frame_out_n`=0.
- R4: From phase cycle 2 until the acknowledge cycle, `ad_oe` and `cbe_oe` are 0, while `frame_oe`=1 and `frame_out_n`=0.
- R5: If `devsel_n`=0 is sampled at the end of any phase cycle c with 2 <= c <= ABORT_CYCLE-1, then phase cycle c+1 shows `ack`=1, `ack_claimed`=1, `ack_abort`=0 and `frame_out_n`=1 with `frame_oe`=1.
- R6: If `devsel_n` stays 1 through phase cycle ABORT_CYCLE-1, then phase cycle ABORT_CYCLE shows `ack`=1, `ack_abort`=1, `ack_claimed`=0 and `frame_out_n`=1 with `frame_oe`=1.
- R7: In the acknowledge cycle of an aborted read (`req_write`=0), `rd_data` is all ones (0xFFFFFFFF at default width). In every other acknowledge cycle it is 0.
- R8: `abort_sticky` goes to 1 in the abort acknowledge cycle and stays 1 until a cycle after `abort_clr`=1 is sampled. A set and a clear on the same edge leave it at 1.
- R9: `ack` is high for exactly one cycle per transaction, and exactly one of `ack_claimed` and `ack_abort` is high with it. `devsel_n` has no effect while no transaction is in progress.
- R10: The cycle after the acknowledge cycle has `frame_oe`=0 and `ack`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Requester asks for a transaction; held until ack |
| req_addr | input | ADDR_W | Target address |
| req_cmd | input | CMD_W | Command code |
| req_write | input | 1 | 1 = write, 0 = read |
| ack | output | 1 | One-cycle completion pulse |
| ack_claimed | output | 1 | Completion was claimed by a target |
| ack_abort | output | 1 | Completion was a master abort |
| rd_data | output | DATA_W | Read data returned with ack |
| abort_sticky | output | 1 | Sticky master-abort flag |
| abort_clr | input | 1 | Write-one-to-clear for the sticky flag |
| gnt_n | input | 1 | Bus grant, active low |
| frame_in_n | input | 1 | Observed frame line, active low |
| irdy_in_n | input | 1 | Observed initiator-ready line, active low |
| devsel_n | input | 1 | Device-select line, active low |
| ad_out | output | ADDR_W | Address lines value |
| ad_oe | output | 1 | Address lines enable |
| cbe_out | output | CMD_W | Command lines value |
| cbe_oe | output | 1 | Command lines enable |
| frame_out_n | output | 1 | Frame value, active low |
| frame_oe | output | 1 | Frame enable |

## Verification
The bench builds the block with 32-bit address and data, a 4-bit command and an abort cycle of 6. With these values every legal claim cycle, from 2 to 5, plus the no-claim case fits in a short sweep. Each is run for reads and writes over several address and command patterns. The expected cycle of every acknowledge follows from the claim cycle by simple arithmetic. The sweep also covers the three ways the start condition can be blocked, device-select activity while the block is idle, and the clear of the sticky flag.

// File: rtl/ainit_pkg.sv
package ainit_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ADDR  = 3'd1,
      ST_WAIT  = 3'd2,
      ST_CLAIM = 3'd3,
      ST_ABORT = 3'd4
   } ainit_state_e;
endpackage

// File: rtl/ainit_window.sv
module ainit_window #(
   parameter int ABORT_CYCLE = 6,
   localparam int CW = $clog2(ABORT_CYCLE + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic step,
   output logic expired
);
   logic [CW-1:0] cyc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cyc_q <= '0;
      else if (load)
         cyc_q <= CW'(2);
      else if (step && cyc_q < CW'(ABORT_CYCLE))
         cyc_q <= cyc_q + 1'b1;
   end

   assign expired = (cyc_q >= CW'(ABORT_CYCLE - 1));
endmodule

// File: rtl/ainit_hold.sv
module ainit_hold #(
   parameter int ADDR_W = 32,
   parameter int CMD_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CMD_W-1:0]  cmd_i,
   input  logic              wr_i,
   output logic [ADDR_W-1:0] addr_q,
   output logic [CMD_W-1:0]  cmd_q,
   output logic              wr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cmd_q  <= '0;
         wr_q   <= 1'b0;
      end else if (capture) begin
         addr_q <= addr_i;
         cmd_q  <= cmd_i;
         wr_q   <= wr_i;
      end
   end
endmodule

// File: rtl/ainit_sticky.sv
module ainit_sticky #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_q
);
   logic flag_d;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb flag_d = set_i | (flag_q & ~clr_i);
      end else begin : g_clr_first
         always_comb flag_d = ~clr_i & (set_i | flag_q);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
   end
endmodule

// File: rtl/ainit_addr_phase.sv
module ainit_addr_phase
   import ainit_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int CMD_W       = 4,
   parameter int DATA_W      = 32,
   parameter int ABORT_CYCLE = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [CMD_W-1:0]  req_cmd,
   input  logic              req_write,
   output logic              ack,
   output logic              ack_claimed,
   output logic              ack_abort,
   output logic [DATA_W-1:0] rd_data,
   output logic              abort_sticky,
   input  logic              abort_clr,
   input  logic              gnt_n,
   input  logic              frame_in_n,
   input  logic              irdy_in_n,
   input  logic              devsel_n,
   output logic [ADDR_W-1:0] ad_out,
   output logic              ad_oe,
   output logic [CMD_W-1:0]  cbe_out,
   output logic              cbe_oe,
   output logic              frame_out_n,
   output logic              frame_oe
);
   generate
      if (ABORT_CYCLE < 3 || ABORT_CYCLE > 16) begin : g_bad_abort
         $error("ABORT_CYCLE must lie in 3..16");
      end
      if (ADDR_W < 1 || CMD_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("widths must be positive");
      end
   endgenerate

   ainit_state_e st_q, st_d;
   logic         bus_free;
   logic         expired;
   logic [ADDR_W-1:0] addr_q;
   logic [CMD_W-1:0]  cmd_q;
   logic              wr_q;

   assign bus_free = ~gnt_n & frame_in_n & irdy_in_n;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:  if (req_valid && bus_free) st_d = ST_ADDR;
         ST_ADDR:  st_d = ST_WAIT;
         ST_WAIT: begin
            if (!devsel_n)    st_d = ST_CLAIM;
            else if (expired) st_d = ST_ABORT;
         end
         ST_CLAIM: st_d = ST_IDLE;
         ST_ABORT: st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   ainit_hold #(.ADDR_W(ADDR_W), .CMD_W(CMD_W)) hold_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (st_q == ST_IDLE && st_d == ST_ADDR),
      .addr_i  (req_addr),
      .cmd_i   (req_cmd),
      .wr_i    (req_write),
      .addr_q  (addr_q),
      .cmd_q   (cmd_q),
      .wr_q    (wr_q)
   );

   ainit_window #(.ABORT_CYCLE(ABORT_CYCLE)) win_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (st_q == ST_ADDR),
      .step    (st_q == ST_WAIT),
      .expired (expired)
   );

   ainit_sticky #(.SET_WINS(1'b1)) sticky_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (st_d == ST_ABORT),
      .clr_i  (abort_clr),
      .flag_q (abort_sticky)
   );

   always_comb begin
      ad_oe       = (st_q == ST_ADDR);
      cbe_oe      = (st_q == ST_ADDR);
      ad_out      = (st_q == ST_ADDR) ? addr_q : '0;
      cbe_out     = (st_q == ST_ADDR) ? cmd_q  : '0;
      frame_oe    = (st_q != ST_IDLE);
      frame_out_n = !(st_q == ST_ADDR || st_q == ST_WAIT);
      ack_claimed = (st_q == ST_CLAIM);
      ack_abort   = (st_q == ST_ABORT);
      ack         = ack_claimed | ack_abort;
      rd_data     = (ack_abort && !wr_q) ? '1 : '0;
   end
endmodule

// File: rtl/ainit_addr_phase_chk.sv
module ainit_addr_phase_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_write,
   input logic              gnt_n,
   input logic              ack,
   input logic              ack_claimed,
   input logic              ack_abort,
   input logic [DATA_W-1:0] rd_data,
   input logic              abort_sticky,
   input logic              ad_oe,
   input logic              cbe_oe,
   input logic              frame_oe,
   input logic              frame_out_n
);
   a_r2_no_start_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_oe && gnt_n) |=> !frame_oe);

   a_r3_addr_cycle_framed: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> (cbe_oe && frame_oe && !frame_out_n));

   a_r4_addr_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |=> (!ad_oe && !cbe_oe && frame_oe && !frame_out_n));

   a_r5_ack_frame_released: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (frame_oe && frame_out_n && !ad_oe));

   a_r7_abort_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_abort && !req_write) |-> (rd_data == {DATA_W{1'b1}}));

   a_r8_sticky_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
      ack_abort |-> abort_sticky);

   a_r9_ack_kind_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> $onehot({ack_claimed, ack_abort}));

   a_r9_ack_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   a_r10_release_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !frame_oe);
endmodule

bind ainit_addr_phase ainit_addr_phase_chk #(.DATA_W(DATA_W)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_write    (req_write),
   .gnt_n        (gnt_n),
   .ack          (ack),
   .ack_claimed  (ack_claimed),
   .ack_abort    (ack_abort),
   .rd_data      (rd_data),
   .abort_sticky (abort_sticky),
   .ad_oe        (ad_oe),
   .cbe_oe       (cbe_oe),
   .frame_oe     (frame_oe),
   .frame_out_n  (frame_out_n)
);

// File: tb/ainit_addr_phase_tb.sv
module ainit_addr_phase_tb_top;
   localparam int AC = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic [3:0]  req_cmd = '0;
   logic        req_write = 1'b0;
   logic        ack, ack_claimed, ack_abort, abort_sticky;
   logic [31:0] rd_data;
   logic        abort_clr = 1'b0;
   logic        gnt_n = 1'b1, frame_in_n = 1'b1, irdy_in_n = 1'b1, devsel_n = 1'b1;
   logic [31:0] ad_out;
   logic        ad_oe, cbe_oe, frame_out_n, frame_oe;
   logic [3:0]  cbe_out;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   ainit_addr_phase #(.ADDR_W(32), .CMD_W(4), .DATA_W(32), .ABORT_CYCLE(AC)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_cmd(req_cmd), .req_write(req_write), .ack(ack), .ack_claimed(ack_claimed),
      .ack_abort(ack_abort), .rd_data(rd_data), .abort_sticky(abort_sticky),
      .abort_clr(abort_clr), .gnt_n(gnt_n), .frame_in_n(frame_in_n),
      .irdy_in_n(irdy_in_n), .devsel_n(devsel_n), .ad_out(ad_out), .ad_oe(ad_oe),
      .cbe_out(cbe_out), .cbe_oe(cbe_oe), .frame_out_n(frame_out_n), .frame_oe(frame_oe));

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   // claim = 0 means no target responds
   task automatic txn(input logic [31:0] a, input logic [3:0] cm, input bit wr, input int claim);
      int endc;
      bit aborted;
      aborted = (claim == 0);
      endc = aborted ? AC : claim + 1;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_cmd = cm; req_write = wr; gnt_n = 1'b0;
      @(negedge clk);
      chk(ad_oe && cbe_oe && frame_oe && !frame_out_n, "R3",
          {28'd0, ad_oe, cbe_oe, frame_oe, frame_out_n}, 32'hE);
      chk(ad_out == a, "R3", ad_out, a);
      chk(cbe_out == cm, "R3", {28'd0, cbe_out}, {28'd0, cm});
      for (int c = 2; c <= endc; c++) begin
         @(negedge clk);
         devsel_n = 1'b1;
         if (c < endc) begin
            chk(!ad_oe && !cbe_oe && frame_oe && !frame_out_n, "R4",
                {29'd0, ad_oe, cbe_oe, frame_out_n}, 32'd0);
            chk(!ack, "R9", {31'd0, ack}, 32'd0);
         end else begin
            chk(ack && frame_oe && frame_out_n, aborted ? "R6" : "R5",
                {29'd0, ack, frame_oe, frame_out_n}, 32'd7);
            chk(ack_claimed == !aborted && ack_abort == aborted, aborted ? "R6" : "R5",
                {30'd0, ack_claimed, ack_abort}, {30'd0, !aborted, aborted});
            chk(rd_data == ((aborted && !wr) ? 32'hFFFF_FFFF : 32'd0), "R7",
                rd_data, (aborted && !wr) ? 32'hFFFF_FFFF : 32'd0);
            chk(abort_sticky == aborted, "R8", {31'd0, abort_sticky}, {31'd0, aborted});
            req_valid = 1'b0; gnt_n = 1'b1;
         end
         if (c == claim) devsel_n = 1'b0;
      end
      @(negedge clk);
      chk(!frame_oe && !ack, "R10", {30'd0, frame_oe, ack}, 32'd0);
      chk(abort_sticky == aborted, "R8", {31'd0, abort_sticky}, {31'd0, aborted});
      abort_clr = 1'b1;
      @(negedge clk);
      abort_clr = 1'b0;
      chk(!abort_sticky, "R8", {31'd0, abort_sticky}, 32'd0);
   endtask

   task automatic blocked(input bit g, input bit f, input bit r);
      @(negedge clk);
      req_valid = 1'b1; req_addr = 32'h1234_5678; gnt_n = g; frame_in_n = f; irdy_in_n = r;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(!ad_oe && !cbe_oe && !frame_oe, "R2", {29'd0, ad_oe, cbe_oe, frame_oe}, 32'd0);
      end
      req_valid = 1'b0; gnt_n = 1'b1; frame_in_n = 1'b1; irdy_in_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      for (int w = 0; w < 20000; w++) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [31:0] addrs [3];
      addrs[0] = 32'h0000_0000; addrs[1] = 32'hFFFF_FFFC; addrs[2] = 32'hA5C3_1E70;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(!ad_oe && !cbe_oe && !frame_oe && !ack && !abort_sticky, "R1",
          {27'd0, ad_oe, cbe_oe, frame_oe, ack, abort_sticky}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!frame_oe && !ack, "R1", {30'd0, frame_oe, ack}, 32'd0);
      // R2 start gating
      blocked(1'b1, 1'b1, 1'b1);
      blocked(1'b0, 1'b0, 1'b1);
      blocked(1'b0, 1'b1, 1'b0);
      // R9 devsel while idle has no effect
      devsel_n = 1'b0;
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(!ack && !frame_oe, "R9", {30'd0, ack, frame_oe}, 32'd0);
      end
      devsel_n = 1'b1;
      // sweep claim cycles, direction, address/command patterns
      for (int ai = 0; ai < 3; ai++)
         for (int wr = 0; wr < 2; wr++)
            for (int cl = 0; cl < AC; cl++)
               if (cl != 1)
                  txn(addrs[ai] ^ 32'(cl << 8), 4'(ai * 5 + cl + wr), wr[0], cl);
      // R8 set and clear on the same edge: set wins
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; gnt_n = 1'b0;
      for (int c = 0; c < AC - 1; c++) @(negedge clk);
      req_valid = 1'b0; gnt_n = 1'b1; abort_clr = 1'b1;
      @(negedge clk);
      chk(ack_abort && abort_sticky, "R8", {30'd0, ack_abort, abort_sticky}, 32'd3);
      abort_clr = 1'b0;
      @(negedge clk);
      chk(abort_sticky, "R8", {31'd0, abort_sticky}, 32'd1);
      summary();
   end
endmodule